// File: doc/BRIEF.md
# Extended Superframe Payload Loopback with Overhead Rebuild

This block sits on the receive side of a T1 line interface. When payload loopback is enabled, it returns the decoded receive bit stream to the transmit side. Only the 192 payload bits of each frame are copied. The framing bit that starts each 193-bit frame is never copied. The block builds each framing bit itself, from one of three sources:

- the fixed framing pattern;
- a CRC-6 that the block computes over the superframe it has just sent;
- a facility data link bit that the block requests from a local source.

The receive framer supplies a superframe alignment mark. The mark sits on the framing bit of frame 1, and the block uses it to set its own frame position. Every transmitted bit is produced one clock after the receive bit enable that carried it. The transmit side is therefore timed entirely by the receive bit timing.

Top module: `esf_payload_loop`

## Requirements
- R1: While reset is asserted, and after it is released, `tx_bit` is 1, `tx_vld` is 0 and `dl_take` is 0 until stimulus arrives.
- R2: When `loop_en` is low, every transmitted bit is 1. When `loop_en` is high but no alignment mark has yet been seen, every transmitted bit is also 1. In both cases `dl_take` stays 0.
- R3: Bit positions 1 to 192 of each frame carry the `rx_bit` value of the same enable, delayed by one clock.
- R4: The framing bits of frames 4, 8, 12, 16, 20 and 24 carry 0, 0, 1, 0, 1, 1 in that order, whatever the received framing bit was.
- R5: The framing bit of every odd frame carries `dl_bit` as it was in the cycle where `dl_take` is high. `dl_take` is high only on those enabled bits.
- R6: The framing bits of frames 2, 6, 10, 14, 18 and 22 carry C1 to C6 in that order. C1..C6 is the remainder, with C1 the coefficient of x^5, of the previous transmitted superframe times x^6, divided by x^6+x+1. In that calculation every framing bit counts as 1.
- R7: In the first superframe after alignment is first gained, the CRC positions carry all zeros.
- R8: `tx_vld` is `rx_bit_en` delayed by one clock. `tx_bit` changes only when `tx_vld` rises with it and otherwise holds.
- R9: An alignment mark, which counts only together with `rx_bit_en`, makes that bit the framing bit of frame 1. If the mark arrives at any other position, the superframe restarts: the CRC being accumulated is discarded, and zeros are sent in the next CRC positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Payload loopback enable |
| rx_bit | input | 1 | Decoded receive data bit |
| rx_bit_en | input | 1 | Receive bit strobe, one per line bit |
| rx_sf_align | input | 1 | Marks the frame-1 framing bit of a receive superframe |
| dl_bit | input | 1 | Data link bit from the local source |
| dl_take | output | 1 | Data link bit consumed this cycle |
| tx_bit | output | 1 | Transmit data bit |
| tx_vld | output | 1 | Transmit bit strobe |

## Verification
The bench builds the block with its default 192-bit payload, so every superframe is a full 4632 bits long. That length brings the real CRC-6 of whole random superframes, and its placement in the following superframe, within reach of the checks. A gapped receive enable makes the hold behaviour between strobes visible at the outputs. Three alignment events exercise R7 and R9: a first lock, a mark placed mid-superframe, and a re-lock after the enable is turned off and on again.

// File: rtl/esf_pkg.sv
package esf_pkg;
    localparam int SF_FRAMES = 24;
    localparam int CRC_W     = 6;
    localparam int GRP_W     = 3;

    // framing pattern, first entry sent in frame 4
    localparam logic [5:0] FPS_SEQ = 6'b001011;

    typedef enum logic [1:0] {
        FB_DL  = 2'd0,
        FB_CRC = 2'd1,
        FB_FPS = 2'd2
    } fbit_kind_e;
endpackage

// File: rtl/esf_position.sv
module esf_position
    import esf_pkg::*;
#(
    parameter int PAYLOAD_BITS = 192,
    localparam int BW = $clog2(PAYLOAD_BITS + 1),
    localparam int FW = $clog2(SF_FRAMES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          loop_en,
    input  logic          bit_en,
    input  logic          sf_align,
    output logic          active,
    output logic [BW-1:0] cur_bit,
    output logic [FW-1:0] cur_frm,
    output logic          restart,
    output logic          sf_last
);
    localparam logic [BW-1:0] LAST_BIT = BW'(PAYLOAD_BITS);
    localparam logic [FW-1:0] LAST_FRM = FW'(SF_FRAMES - 1);

    typedef struct packed {
        logic          synced;
        logic [BW-1:0] bit_idx;
        logic [FW-1:0] frm_idx;
    } pos_t;

    pos_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        cur_bit = sf_align ? '0 : st_q.bit_idx;
        cur_frm = sf_align ? '0 : st_q.frm_idx;
        active  = loop_en && bit_en && (sf_align || st_q.synced);
        restart = loop_en && bit_en && sf_align &&
                  (!st_q.synced || st_q.bit_idx != '0 || st_q.frm_idx != '0);
        sf_last = active && cur_frm == LAST_FRM && cur_bit == LAST_BIT;
        if (!loop_en) begin
            st_d = '0;
        end else if (active) begin
            st_d.synced = 1'b1;
            if (cur_bit == LAST_BIT) begin
                st_d.bit_idx = '0;
                st_d.frm_idx = (cur_frm == LAST_FRM) ? '0 : cur_frm + 1'b1;
            end else begin
                st_d.bit_idx = cur_bit + 1'b1;
                st_d.frm_idx = cur_frm;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_align_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && bit_en && sf_align) |=>
            (st_q.synced && st_q.bit_idx == BW'(1) && st_q.frm_idx == '0));

    assert_pos_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bit_idx <= LAST_BIT && st_q.frm_idx <= LAST_FRM));

    assert_unsync_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |=> !st_q.synced);
endmodule

// File: rtl/esf_crc6.sv
module esf_crc6
    import esf_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY_LOW = 6'b000011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loop_en,
    input  logic             step,
    input  logic             din,
    input  logic             clear,
    input  logic             last,
    output logic [CRC_W-1:0] crc_tx
);
    typedef struct packed {
        logic [CRC_W-1:0] acc;
        logic [CRC_W-1:0] held;
    } crc_t;

    crc_t st_d, st_q;
    logic [CRC_W-1:0] acc_base;
    logic [CRC_W-1:0] acc_next;
    logic             fb;

    always_comb begin
        st_d     = st_q;
        acc_base = clear ? '0 : st_q.acc;
        fb       = din ^ acc_base[CRC_W-1];
        acc_next = {acc_base[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY_LOW);
        if (clear) st_d.held = '0;
        if (!loop_en) begin
            st_d = '0;
        end else if (step) begin
            if (last) begin
                st_d.held = acc_next;
                st_d.acc  = '0;
            end else begin
                st_d.acc  = acc_next;
            end
        end
    end

    assign crc_tx = st_q.held;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_crc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !last) |=> (st_q.held == '0));
endmodule

// File: rtl/esf_fbit_sel.sv
module esf_fbit_sel
    import esf_pkg::*;
#(
    localparam int FW = $clog2(SF_FRAMES)
) (
    input  logic [FW-1:0]    cur_frm,
    input  logic [CRC_W-1:0] crc_tx,
    input  logic             dl_bit,
    output logic             fbit,
    output fbit_kind_e       kind
);
    logic [GRP_W-1:0] grp;

    always_comb begin
        grp = cur_frm[FW-1:2];
        if (!cur_frm[0]) begin
            kind = FB_DL;
            fbit = dl_bit;
        end else if (!cur_frm[1]) begin
            kind = FB_CRC;
            fbit = crc_tx[CRC_W - 1 - int'(grp)];
        end else begin
            kind = FB_FPS;
            fbit = FPS_SEQ[5 - int'(grp)];
        end
    end
endmodule

// File: rtl/esf_payload_loop.sv
module esf_payload_loop
    import esf_pkg::*;
#(
    parameter int PAYLOAD_BITS = 192,
    localparam int BW = $clog2(PAYLOAD_BITS + 1),
    localparam int FW = $clog2(SF_FRAMES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_en,
    input  logic rx_bit,
    input  logic rx_bit_en,
    input  logic rx_sf_align,
    input  logic dl_bit,
    output logic dl_take,
    output logic tx_bit,
    output logic tx_vld
);
    typedef struct packed {
        logic bit_v;
        logic vld;
    } out_t;

    out_t st_d, st_q;

    logic             active;
    logic [BW-1:0]    cur_bit;
    logic [FW-1:0]    cur_frm;
    logic             restart;
    logic             sf_last;
    logic [CRC_W-1:0] crc_tx;
    logic             fbit;
    fbit_kind_e       kind;
    logic             is_fpos;
    logic             crc_din;

    esf_position #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_pos (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .bit_en(rx_bit_en),
        .sf_align(rx_sf_align), .active(active), .cur_bit(cur_bit),
        .cur_frm(cur_frm), .restart(restart), .sf_last(sf_last)
    );

    esf_crc6 u_crc (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .step(active),
        .din(crc_din), .clear(restart), .last(sf_last), .crc_tx(crc_tx)
    );

    esf_fbit_sel u_fsel (
        .cur_frm(cur_frm), .crc_tx(crc_tx), .dl_bit(dl_bit),
        .fbit(fbit), .kind(kind)
    );

    always_comb begin
        is_fpos = (cur_bit == '0);
        crc_din = is_fpos ? 1'b1 : rx_bit;
        dl_take = active && is_fpos && kind == FB_DL;
        st_d    = st_q;
        st_d.vld = rx_bit_en;
        if (rx_bit_en) begin
            if (!active)      st_d.bit_v = 1'b1;
            else if (is_fpos) st_d.bit_v = fbit;
            else              st_d.bit_v = rx_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{bit_v: 1'b1, vld: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_bit = st_q.bit_v;
    assign tx_vld = st_q.vld;

    assert_idle_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_en && rx_bit_en) |=> tx_bit);

    assert_vld_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_en |=> tx_vld);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_bit_en |=> (!tx_vld && $stable(tx_bit)));

    assert_dl_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dl_take |-> (rx_bit_en && loop_en));

    assert_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cur_bit != '0) |=> (tx_bit == $past(rx_bit)));
endmodule

// File: tb/sim_esf_payload_loop.sv
module sim_esf_payload_loop;
    localparam int PB  = 192;
    localparam int FB  = PB + 1;
    localparam int SFB = 24 * FB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_en = 1'b0, rx_bit = 1'b0, rx_bit_en = 1'b0;
    logic rx_sf_align = 1'b0, dl_bit = 1'b0;
    logic dl_take, tx_bit, tx_vld;

    always #2.5 clk = ~clk;

    esf_payload_loop u0 (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .rx_bit(rx_bit),
        .rx_bit_en(rx_bit_en), .rx_sf_align(rx_sf_align), .dl_bit(dl_bit),
        .dl_take(dl_take), .tx_bit(tx_bit), .tx_vld(tx_vld)
    );

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural reference state
    bit    m_sync = 0;
    int    m_pos = 0;
    int    m_first = 0;
    int    m_crc = 0;
    bit    m_bits[$];
    bit    exp_bit = 1;
    bit    exp_vld = 0;
    string exp_tag = "R1";
    int    fps_tab[6] = '{0, 0, 1, 0, 1, 1};

    function automatic int crc_of_queue();
        bit r[];
        int n;
        int g[7] = '{1, 0, 0, 0, 0, 1, 1};
        int res = 0;
        n = m_bits.size();
        r = new[n + 6];
        for (int i = 0; i < n; i++) r[i] = m_bits[i];
        for (int i = n; i < n + 6; i++) r[i] = 0;
        for (int i = 0; i < n; i++)
            if (r[i]) for (int k = 0; k < 7; k++) r[i + k] = r[i + k] ^ g[k][0];
        for (int i = 0; i < 6; i++) res = (res << 1) | int'(r[n + i]);
        return res;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sync = 0; exp_bit = 1; exp_vld = 0; exp_tag = "R1";
        end else begin
            int f, b;
            if (!loop_en) m_sync = 0;
            exp_vld = rx_bit_en;
            if (rx_bit_en) begin
                if (!loop_en) begin
                    exp_bit = 1; exp_tag = "R2";
                end else begin
                    if (rx_sf_align) begin
                        if (!(m_sync && m_pos == 0)) begin
                            m_first = m_sync ? 2 : 1;
                            m_sync = 1; m_crc = 0; m_bits.delete();
                        end
                        m_pos = 0;
                    end
                    if (!m_sync) begin
                        exp_bit = 1; exp_tag = "R2";
                    end else begin
                        f = m_pos / FB; b = m_pos % FB;
                        if (b != 0) begin
                            exp_bit = rx_bit; exp_tag = "R3"; m_bits.push_back(rx_bit);
                        end else begin
                            m_bits.push_back(1'b1);
                            if (f % 2 == 0) begin
                                exp_bit = dl_bit; exp_tag = "R5";
                            end else if (f % 4 == 1) begin
                                exp_bit = m_crc[5 - f / 4];
                                exp_tag = (m_first == 1) ? "R7" : (m_first == 2) ? "R9" : "R6";
                            end else begin
                                exp_bit = fps_tab[f / 4][0]; exp_tag = "R4";
                            end
                        end
                        m_pos++;
                        if (m_pos == SFB) begin
                            m_crc = crc_of_queue(); m_bits.delete(); m_pos = 0; m_first = 0;
                        end
                    end
                end
            end
        end
    end

    function automatic bit pred_take();
        if (!(loop_en && rx_bit_en)) return 0;
        if (rx_sf_align) return 1;
        if (!m_sync) return 0;
        return (m_pos % FB == 0) && ((m_pos / FB) % 2 == 0);
    endfunction

    task automatic check(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    int rx_cnt = 0;

    // one cycle: compare registered outputs, drive new inputs, check dl_take
    task automatic cyc(bit en, bit le, bit aligned);
        @(negedge clk);
        check({exp_tag, " tx_bit"}, tx_bit, exp_bit);
        check("R8 tx_vld", tx_vld, exp_vld);
        loop_en     = le;
        rx_bit_en   = en;
        rx_bit      = 1'($urandom);
        dl_bit      = 1'($urandom);
        rx_sf_align = en && aligned && (rx_cnt % SFB == 0);
        if (en) rx_cnt++;
        #1;
        check("R5 dl_take", dl_take, pred_take());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 tx_bit", tx_bit, 1);
        check("R1 tx_vld", tx_vld, 0);
        check("R1 dl_take", dl_take, 0);
        rst_n = 1'b1;
        repeat (4) cyc(0, 0, 0);
        // R2: loopback off, then on without alignment
        for (int i = 0; i < 300; i++) cyc(($urandom % 4) != 0, 0, 0);
        for (int i = 0; i < 300; i++) cyc(($urandom % 4) != 0, 1, 0);
        // first lock and three full superframes: R3..R7
        rx_cnt = 0;
        while (rx_cnt < 3 * SFB + 50) cyc(($urandom % 4) != 0, 1, 1);
        // R9: mark placed mid-superframe
        rx_cnt = 0;
        while (rx_cnt < 2 * SFB + 10) cyc(($urandom % 4) != 0, 1, 1);
        // turn off then re-lock
        for (int i = 0; i < 100; i++) cyc(($urandom % 3) != 0, 0, 0);
        rx_cnt = 0;
        while (rx_cnt < SFB + 20) cyc(($urandom % 4) != 0, 1, 1);
        cyc(0, 1, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule